// File: doc/BRIEF.md
# PWM Action-Word Shadow Loader

This block keeps the two action-control words that an action-qualifier stage uses to decide what each PWM output does on time-base events. There is one word for output channel A and one for channel B. Each word exists twice: a shadow copy that software stages, and an active copy that the qualifier logic reads. A small register bus can write and read either copy, a control word, and a status word. The time-base counter, the compare units and the output logic live elsewhere. Counter-at-zero, counter-at-period and global-load strobes arrive as single-cycle input pulses.

Each channel has its own two-bit field that selects which strobe copies its shadow word into its active word. The choices are zero, period, either of the two, or never. A global-load enable overrides both fields, and the transfer for both words then happens only on the shared global strobe. Software can also write an active word directly for an immediate change, but only while global load is off. A direct write attempted while global load is on is dropped and raises a sticky error bit.

The active words come straight from registers. On the cycle of a load strobe, the qualifier still sees the old word, so an action due at a counter-zero instant is evaluated against a settled word. The new word applies from the next cycle.

Top module: `pwm_aq_shadow_loader`

## Requirements
- R1: A bus write to a shadow address (A: 0, B: 2) updates only that shadow copy. The active word stays unchanged until a load occurs.
- R2: The control word (address 4) holds channel A's load mode in bits [1:0] and channel B's in bits [3:2]. The encodings are 00 = load on the zero strobe, 01 = load on the period strobe, 10 = load on either strobe. Each channel responds only to its own field.
- R3: Load mode 11 freezes a channel. No local strobe copies its shadow word.
- R4: When control bit 4 (global enable) is 1, both channels ignore their mode fields and the zero and period strobes, and both load only on the global strobe. When bit 4 is 0, the global strobe has no effect.
- R5: A bus write to an active address (A: 1, B: 3) while global enable is 0 replaces that active word at the next clock edge. If a load strobe for that channel arrives in the same cycle, the load wins.
- R6: A bus write to an active address while global enable is 1 leaves the active word unchanged and sets a sticky error bit. The error bit appears on the error output and at bit 0 of the status word (address 5). Writing the status word with bit 0 set clears the bit.
- R7: A shadow write that coincides with a load strobe for that channel transfers the value written in that same cycle.
- R8: On the cycle a load strobe is present, the active output still shows the previous word. The new word is visible from the next cycle.
- R9: Synchronous reset clears both shadow and both active words, sets both load modes to 00, and clears the global enable and the error bit.
- R10: The read data shows the word at the presented address one cycle after that address is presented. Reading never changes any stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_zero | input | 1 | Counter-at-zero strobe |
| evt_period | input | 1 | Counter-at-period strobe |
| evt_global | input | 1 | Shared global-load strobe |
| bus_we | input | 1 | Register write enable |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | WORD_W | Register write data |
| bus_rdata | output | WORD_W | Registered read data |
| act_a | output | WORD_W | Active action word, channel A |
| act_b | output | WORD_W | Active action word, channel B |
| cfg_err | output | 1 | Sticky flag for a blocked direct active write |

## Verification
The bench drives channels A and B in different load modes, so that a design which shares one mode field, or swaps the zero and period choices, loads the wrong channel and shows a wrong active word. It pairs a shadow write with a load strobe to expose a design that transfers the stale shadow word. It pairs a direct active write with a load strobe to expose a design that lets the write win. It samples the active word inside the strobe cycle to catch a combinational bypass that would change the word under a zero-count action. It sends zero and period strobes with global enable set, and a global strobe with it clear, to catch a leaky override. It reads status twice before clearing it, to catch an error bit that clears on read or never sets.

// File: rtl/pwm_aq_pkg.sv
package pwm_aq_pkg;
  typedef enum logic [1:0] {
    LD_ON_ZERO   = 2'b00,
    LD_ON_PRD    = 2'b01,
    LD_ON_EITHER = 2'b10,
    LD_FROZEN    = 2'b11
  } ld_mode_e;

  localparam int NUM_CH    = 2;
  localparam int MODE_W    = 2;
  localparam int GLB_BIT   = NUM_CH * MODE_W;
  localparam int CTRL_SLOT = 2 * NUM_CH;
  localparam int STAT_SLOT = 2 * NUM_CH + 1;
endpackage

// File: rtl/pwm_aq_load_sel.sv
module pwm_aq_load_sel
  import pwm_aq_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  input  logic              glb_en_i,
  input  logic              evt_zero_i,
  input  logic              evt_prd_i,
  input  logic              evt_glb_i,
  output logic              load_o
);
  always_comb begin
    if (glb_en_i) begin
      load_o = evt_glb_i;
    end else begin
      case (ld_mode_e'(mode_i))
        LD_ON_ZERO:   load_o = evt_zero_i;
        LD_ON_PRD:    load_o = evt_prd_i;
        LD_ON_EITHER: load_o = evt_zero_i | evt_prd_i;
        default:      load_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/pwm_aq_chan.sv
module pwm_aq_chan #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sh_we_i,
  input  logic         act_we_i,
  input  logic [W-1:0] wdata_i,
  input  logic         load_i,
  output logic [W-1:0] sh_q_o,
  output logic [W-1:0] act_q_o
);
  logic [W-1:0] sh_next;

  always_comb sh_next = sh_we_i ? wdata_i : sh_q_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q_o  <= '0;
      act_q_o <= '0;
    end else begin
      sh_q_o <= sh_next;
      if (load_i)        act_q_o <= sh_next;
      else if (act_we_i) act_q_o <= wdata_i;
    end
  end

  AST_SHADOW_TAKES_WRITE: assert property (@(posedge clk) disable iff (rst)
    sh_we_i |=> sh_q_o == $past(wdata_i)); // R1
  AST_LOAD_FROM_SHADOW: assert property (@(posedge clk) disable iff (rst)
    (load_i && !sh_we_i) |=> act_q_o == $past(sh_q_o)); // R2
  AST_LOAD_SAME_CYCLE_WRITE: assert property (@(posedge clk) disable iff (rst)
    (load_i && sh_we_i) |=> act_q_o == $past(wdata_i)); // R7
  AST_ACTIVE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !act_we_i) |=> $stable(act_q_o)); // R8
  AST_DIRECT_WRITE: assert property (@(posedge clk) disable iff (rst)
    (act_we_i && !load_i) |=> act_q_o == $past(wdata_i)); // R5
  AST_CHAN_RESET: assert property (@(posedge clk)
    rst |=> (act_q_o == '0 && sh_q_o == '0)); // R9
endmodule

// File: rtl/pwm_aq_regif.sv
module pwm_aq_regif
  import pwm_aq_pkg::*;
#(
  parameter int W      = 12,
  parameter int ADDR_W = 3
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           we_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [W-1:0]                   wdata_i,
  input  logic [NUM_CH-1:0][W-1:0]       sh_q_i,
  input  logic [NUM_CH-1:0][W-1:0]       act_q_i,
  output logic [NUM_CH-1:0][MODE_W-1:0]  mode_o,
  output logic                           glb_en_o,
  output logic                           err_o,
  output logic [W-1:0]                   rdata_o
);
  // W must exceed GLB_BIT so the control word fits.
  logic           ctrl_hit, stat_hit, act_hit, bad_wr;
  logic [W-1:0]   rd_mux;

  always_comb begin
    act_hit = 1'b0;
    for (int c = 0; c < NUM_CH; c++)
      if (addr_i == ADDR_W'(2 * c + 1)) act_hit = 1'b1;
  end

  assign ctrl_hit = (addr_i == ADDR_W'(CTRL_SLOT));
  assign stat_hit = (addr_i == ADDR_W'(STAT_SLOT));
  assign bad_wr   = we_i && act_hit && glb_en_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_o   <= '0;
      glb_en_o <= 1'b0;
    end else if (we_i && ctrl_hit) begin
      for (int c = 0; c < NUM_CH; c++)
        mode_o[c] <= wdata_i[c*MODE_W +: MODE_W];
      glb_en_o <= wdata_i[GLB_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                              err_o <= 1'b0;
    else if (bad_wr)                      err_o <= 1'b1;
    else if (we_i && stat_hit && wdata_i[0]) err_o <= 1'b0;
  end

  always_comb begin
    rd_mux = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (addr_i == ADDR_W'(2 * c))     rd_mux = sh_q_i[c];
      if (addr_i == ADDR_W'(2 * c + 1)) rd_mux = act_q_i[c];
    end
    if (ctrl_hit) begin
      for (int c = 0; c < NUM_CH; c++)
        rd_mux[c*MODE_W +: MODE_W] = mode_o[c];
      rd_mux[GLB_BIT] = glb_en_o;
    end
    if (stat_hit) rd_mux[0] = err_o;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else     rdata_o <= rd_mux;
  end

  AST_ERR_RAISE: assert property (@(posedge clk) disable iff (rst)
    (we_i && act_hit && glb_en_o) |=> err_o); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (err_o && !(we_i && stat_hit)) |=> err_o); // R6
  AST_CTRL_STABLE_ON_READ: assert property (@(posedge clk) disable iff (rst)
    !we_i |=> ($stable(mode_o) && $stable(glb_en_o))); // R10
  AST_CTRL_RESET: assert property (@(posedge clk)
    rst |=> (mode_o == '0 && !glb_en_o && !err_o)); // R9
endmodule

// File: rtl/pwm_aq_shadow_loader.sv
module pwm_aq_shadow_loader
  import pwm_aq_pkg::*;
#(
  parameter int WORD_W = 12,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evt_zero,
  input  logic              evt_period,
  input  logic              evt_global,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic [WORD_W-1:0] act_a,
  output logic [WORD_W-1:0] act_b,
  output logic              cfg_err
);
  logic [NUM_CH-1:0][MODE_W-1:0] mode;
  logic                          glb_en;
  logic [NUM_CH-1:0][WORD_W-1:0] sh_q, act_q;
  logic [NUM_CH-1:0]             sh_we, act_we, load;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    assign sh_we[ch]  = bus_we && (bus_addr == ADDR_W'(2 * ch));
    assign act_we[ch] = bus_we && (bus_addr == ADDR_W'(2 * ch + 1)) && !glb_en;

    pwm_aq_load_sel u_sel (
      .mode_i    (mode[ch]),
      .glb_en_i  (glb_en),
      .evt_zero_i(evt_zero),
      .evt_prd_i (evt_period),
      .evt_glb_i (evt_global),
      .load_o    (load[ch])
    );

    pwm_aq_chan #(.W(WORD_W)) u_chan (
      .clk     (clk),
      .rst     (rst),
      .sh_we_i (sh_we[ch]),
      .act_we_i(act_we[ch]),
      .wdata_i (bus_wdata),
      .load_i  (load[ch]),
      .sh_q_o  (sh_q[ch]),
      .act_q_o (act_q[ch])
    );
  end

  pwm_aq_regif #(.W(WORD_W), .ADDR_W(ADDR_W)) u_regif (
    .clk     (clk),
    .rst     (rst),
    .we_i    (bus_we),
    .addr_i  (bus_addr),
    .wdata_i (bus_wdata),
    .sh_q_i  (sh_q),
    .act_q_i (act_q),
    .mode_o  (mode),
    .glb_en_o(glb_en),
    .err_o   (cfg_err),
    .rdata_o (bus_rdata)
  );

  assign act_a = act_q[0];
  assign act_b = act_q[1];

  AST_GLB_BLOCKS_LOCAL: assert property (@(posedge clk) disable iff (rst)
    (glb_en && !evt_global) |=> ($stable(act_a) && $stable(act_b))); // R4
  AST_FROZEN_A: assert property (@(posedge clk) disable iff (rst)
    (!glb_en && mode[0] == LD_FROZEN && !act_we[0]) |=> $stable(act_a)); // R3
  AST_GLB_OFF_IGNORES: assert property (@(posedge clk) disable iff (rst)
    (!glb_en && !evt_zero && !evt_period && !bus_we) |=> ($stable(act_a) && $stable(act_b))); // R4
endmodule

// File: tb/pwm_aq_shadow_loader_test.sv
module pwm_aq_shadow_loader_test;
  localparam int W  = 12;
  localparam int AW = 3;

  typedef struct packed {
    logic          we;
    logic [AW-1:0] addr;
    logic [W-1:0]  wdata;
    logic          ez;
    logic          ep;
    logic          eg;
    logic [W-1:0]  exp_a;
    logic [W-1:0]  exp_b;
    logic [3:0]    req;
  } vec_t;

  localparam int NV = 24;
  // Addresses: 0 A shadow, 1 A active, 2 B shadow, 3 B active, 4 control, 5 status
  localparam vec_t VECS [NV] = '{
    '{1'b1, 3'd0, 12'h111, 1'b0, 1'b0, 1'b0, 12'h000, 12'h000, 4'd1},  // R1
    '{1'b1, 3'd2, 12'h222, 1'b0, 1'b0, 1'b0, 12'h000, 12'h000, 4'd1},  // R1
    '{1'b0, 3'd0, 12'h000, 1'b1, 1'b0, 1'b0, 12'h111, 12'h222, 4'd2},  // R2 zero load
    '{1'b1, 3'd4, 12'h009, 1'b0, 1'b0, 1'b0, 12'h111, 12'h222, 4'd2},  // A prd, B either
    '{1'b1, 3'd0, 12'h333, 1'b0, 1'b0, 1'b0, 12'h111, 12'h222, 4'd1},
    '{1'b0, 3'd0, 12'h000, 1'b1, 1'b0, 1'b0, 12'h111, 12'h222, 4'd2},  // R2 A skips zero
    '{1'b1, 3'd2, 12'h444, 1'b0, 1'b0, 1'b0, 12'h111, 12'h222, 4'd1},
    '{1'b0, 3'd0, 12'h000, 1'b0, 1'b1, 1'b0, 12'h333, 12'h444, 4'd2},  // R2 period
    '{1'b1, 3'd4, 12'h003, 1'b0, 1'b0, 1'b0, 12'h333, 12'h444, 4'd3},  // A frozen, B zero
    '{1'b1, 3'd0, 12'h555, 1'b1, 1'b0, 1'b0, 12'h333, 12'h444, 4'd3},  // R3
    '{1'b1, 3'd2, 12'h666, 1'b1, 1'b0, 1'b0, 12'h333, 12'h666, 4'd7},  // R7
    '{1'b1, 3'd1, 12'h0AB, 1'b0, 1'b0, 1'b0, 12'h0AB, 12'h666, 4'd5},  // R5
    '{1'b1, 3'd3, 12'h0CD, 1'b0, 1'b0, 1'b0, 12'h0AB, 12'h0CD, 4'd5},
    '{1'b1, 3'd4, 12'h010, 1'b0, 1'b0, 1'b0, 12'h0AB, 12'h0CD, 4'd4},  // global on
    '{1'b1, 3'd0, 12'h777, 1'b1, 1'b0, 1'b0, 12'h0AB, 12'h0CD, 4'd4},  // R4 zero ignored
    '{1'b0, 3'd0, 12'h000, 1'b0, 1'b1, 1'b0, 12'h0AB, 12'h0CD, 4'd4},
    '{1'b0, 3'd0, 12'h000, 1'b0, 1'b0, 1'b1, 12'h777, 12'h666, 4'd4},  // R4 global load
    '{1'b1, 3'd1, 12'h123, 1'b0, 1'b0, 1'b0, 12'h777, 12'h666, 4'd6},  // R6 blocked
    '{1'b1, 3'd2, 12'h999, 1'b0, 1'b0, 1'b1, 12'h777, 12'h999, 4'd7},
    '{1'b1, 3'd4, 12'h000, 1'b0, 1'b0, 1'b0, 12'h777, 12'h999, 4'd4},  // global off
    '{1'b1, 3'd0, 12'h0EE, 1'b0, 1'b0, 1'b0, 12'h777, 12'h999, 4'd1},
    '{1'b0, 3'd0, 12'h000, 1'b0, 1'b0, 1'b1, 12'h777, 12'h999, 4'd4},  // R4 strobe ignored
    '{1'b0, 3'd0, 12'h000, 1'b1, 1'b0, 1'b0, 12'h0EE, 12'h999, 4'd2},
    '{1'b1, 3'd1, 12'h456, 1'b1, 1'b0, 1'b0, 12'h0EE, 12'h999, 4'd5}   // R5 load wins
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic evt_zero = 1'b0, evt_period = 1'b0, evt_global = 1'b0, bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [W-1:0]  bus_wdata = '0;
  logic [W-1:0]  bus_rdata, act_a, act_b;
  logic          cfg_err;
  int  n_chk = 0, n_bad = 0;
  bit  done = 1'b0;

  always #5 clk = ~clk;

  pwm_aq_shadow_loader #(.WORD_W(W), .ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .evt_zero(evt_zero), .evt_period(evt_period),
    .evt_global(evt_global), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .act_a(act_a),
    .act_b(act_b), .cfg_err(cfg_err)
  );

  task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic drive(input logic we, input logic [AW-1:0] a, input logic [W-1:0] d,
                       input logic ez, input logic ep, input logic eg);
    @(negedge clk);
    bus_we = we; bus_addr = a; bus_wdata = d;
    evt_zero = ez; evt_period = ep; evt_global = eg;
    @(posedge clk); #1;
    bus_we = 1'b0; evt_zero = 1'b0; evt_period = 1'b0; evt_global = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [W-1:0] exp, input string req);
    drive(1'b0, a, '0, 1'b0, 1'b0, 1'b0);
    check(req, bus_rdata, exp);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R9: reset state
    check("R9 act_a", act_a, '0);
    check("R9 act_b", act_b, '0);
    check("R9 err", {11'b0, cfg_err}, '0);
    rd(3'd4, 12'h000, "R9 ctrl");

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].we, VECS[i].addr, VECS[i].wdata, VECS[i].ez, VECS[i].ep, VECS[i].eg);
      check($sformatf("R%0d vec%0d a", VECS[i].req, i), act_a, VECS[i].exp_a);
      check($sformatf("R%0d vec%0d b", VECS[i].req, i), act_b, VECS[i].exp_b);
    end

    // R8: word unchanged during the strobe cycle, new one after
    drive(1'b1, 3'd0, 12'hABC, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    evt_zero = 1'b1;
    #2 check("R8 during strobe", act_a, 12'h0EE);
    @(posedge clk); #1;
    evt_zero = 1'b0;
    check("R8 after strobe", act_a, 12'hABC);

    // R10: read map, no side effects
    rd(3'd0, 12'hABC, "R10 A shadow");
    rd(3'd3, 12'h999, "R10 B active");
    rd(3'd4, 12'h000, "R10 ctrl");
    check("R10 act_a unchanged", act_a, 12'hABC);
    // R6: sticky error, read does not clear, write-1 clears
    rd(3'd5, 12'h001, "R6 status set");
    rd(3'd5, 12'h001, "R6 status after read");
    drive(1'b1, 3'd5, 12'h001, 1'b0, 1'b0, 1'b0);
    check("R6 err cleared", {11'b0, cfg_err}, '0);
    rd(3'd5, 12'h000, "R6 status cleared");

    // R9: reset after activity
    drive(1'b1, 3'd4, 12'h01F, 1'b0, 1'b0, 1'b0);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    check("R9 act_a after reset", act_a, '0);
    check("R9 act_b after reset", act_b, '0);
    rd(3'd0, 12'h000, "R9 A shadow");
    rd(3'd4, 12'h000, "R9 ctrl");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule